// File: doc/BRIEF.md
# Direct-Mapped Data Cache with Gated Line Allocation

This block is a small direct-mapped data cache placed between a single load/store requester and a simple word-wide memory port. Every request is looked up against the resident line tags, whatever the configuration. A load hit returns the cached word. A store hit writes the word into its line. A store hit to a region flagged write-through is also copied out to memory, and the response waits for that write to finish. A store hit to a write-back region marks the line dirty.

A miss may bring a line into the cache only when three conditions hold together: the global cache enable is set, the address-translation enable is set, and the request carries its cacheable flag. Any other miss is passed through as a single memory access at the request address, and the cache is left untouched. Clearing the cache enable therefore stops refills but does not stop lookups. An allocating miss first writes back a dirty victim, then fills the line, and then looks up the request again so that it completes as a hit.

Requests use a valid/ready handshake with at most one request outstanding. Each accepted request produces exactly one response pulse. Addresses are word addresses. The default geometry is 16 lines of 4 words of 32 bits.

Top module: `dcache_gated`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid is 0 and mem_valid is 0, and every line is invalid, so the first access to any address misses.
- R2: A load hit returns the last value stored to that word and makes no memory access. rsp_valid rises on the second falling clock edge after the rising edge that accepts the request.
- R3: A store hit to a write-back region (req_wthru=0) updates the cached word and makes no memory access. A later load hit returns the new value.
- R4: A store hit to a write-through region (req_wthru=1) updates the cached word and issues exactly one memory write of the same data to the request address. The response follows that write.
- R5: A miss fills a line only when cfg_cache_en, cfg_xlat_en and req_cacheable are all 1. If any of the three is 0, the miss makes exactly one memory access and a repeat of the same access misses again.
- R6: A non-allocating miss makes one memory access at req_addr. For a load, the response carries the memory word. For a store, req_wdata is written to memory.
- R7: With cfg_cache_en=0, lookups continue: a load hit returns cached data and a store hit writes the cache, both without memory traffic. A cacheable miss does not replace the resident line.
- R8: A line fill reads the four words of the line in ascending offset order, starting from the line base (offset bits 0). The line becomes valid only after the last word has been written.
- R9: Before the fill starts, an allocating miss whose victim line is valid and dirty writes the victim's four words to memory, in ascending order at the victim's own address.
- R10: req_ready is 1 only while the block is idle, so a second request cannot be accepted while one is in progress. A memory request, once raised, keeps its address, direction and data unchanged until mem_ready accepts it.
- R11: Each accepted request gives exactly one rsp_valid pulse, one cycle long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cfg_cache_en | input | 1 | Global cache enable; gates allocation only |
| cfg_xlat_en | input | 1 | Address-translation enable; gates allocation |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block is idle and accepts a request |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | 16 | Word address: tag [15:6], line index [5:2], word offset [1:0] |
| req_wdata | input | 32 | Store data |
| req_cacheable | input | 1 | Per-access cacheable attribute |
| req_wthru | input | 1 | 1 = write-through region, 0 = write-back region |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Load data (0 for stores) |
| mem_valid | output | 1 | Memory beat request |
| mem_ready | input | 1 | Memory accepts the beat this cycle; read data is valid in the same cycle |
| mem_write | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | 16 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, sampled when mem_valid and mem_ready are both 1 |

## Verification
In one lookup cycle the block can both write a word into the data array and start the write-through memory write that carries the same word. The bench provokes this with write-through store hits while mem_ready is throttled, so the memory beat is held across stall cycles. It then judges the result at both ends: the bench memory must hold the stored value after exactly one write at that address, and a following load must hit in the cache with that value. A second overlap, where a dirty victim is written back just before the refill of the same index, is judged by the order of memory beats: four writes at the old line address, then four reads at the new one.

// File: rtl/dcg_pkg.sv
package dcg_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_LOOK  = 3'd1,
    ST_EVICT = 3'd2,
    ST_FILL  = 3'd3,
    ST_PASS  = 3'd4,
    ST_WT    = 3'd5
  } dcg_state_t;
endpackage

// File: rtl/dcg_tag_array.sv
module dcg_tag_array #(
  parameter int IDX_W = 4,
  parameter int TAG_W = 10,
  localparam int LINES = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] idx,
  output logic             rd_valid,
  output logic             rd_dirty,
  output logic [TAG_W-1:0] rd_tag,
  input  logic             inv_en,
  input  logic             fill_en,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic             dirty_en
);
  logic [LINES-1:0] valid_q;
  logic [LINES-1:0] dirty_q;
  logic [TAG_W-1:0] tag_q [LINES];

  for (genvar l = 0; l < LINES; l++) begin : g_line
    logic sel;
    logic valid_d, dirty_d, ce;
    assign sel = (idx == IDX_W'(l));

    always_comb begin
      valid_d = valid_q[l];
      dirty_d = dirty_q[l];
      ce      = 1'b0;
      if (sel && inv_en) begin
        valid_d = 1'b0;
        dirty_d = 1'b0;
        ce      = 1'b1;
      end else if (sel && fill_en) begin
        valid_d = 1'b1;
        dirty_d = 1'b0;
        ce      = 1'b1;
      end else if (sel && dirty_en) begin
        dirty_d = 1'b1;
        ce      = 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid_q[l] <= 1'b0;
        dirty_q[l] <= 1'b0;
      end else if (ce) begin
        valid_q[l] <= valid_d;
        dirty_q[l] <= dirty_d;
      end
    end

    always_ff @(posedge clk) begin
      if (sel && fill_en) begin
        tag_q[l] <= fill_tag;
      end
    end
  end

  assign rd_valid = valid_q[idx];
  assign rd_dirty = dirty_q[idx];
  assign rd_tag   = tag_q[idx];

  // R8: a line is completed only while it is still invalid
  p_fill_on_invalid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |-> !valid_q[idx]);

  // R3: only a resident line can be marked dirty
  p_dirty_on_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dirty_en |-> valid_q[idx]);

  // R9: a filled line starts clean
  p_fill_clean_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |=> !dirty_q[$past(idx)]);
endmodule

// File: rtl/dcg_data_array.sv
module dcg_data_array #(
  parameter int IDX_W  = 4,
  parameter int OFS_W  = 2,
  parameter int DATA_W = 32,
  localparam int LINES = 1 << IDX_W,
  localparam int WORDS = 1 << OFS_W
) (
  input  logic              clk,
  input  logic [IDX_W-1:0]  idx,
  input  logic [OFS_W-1:0]  rd_ofs,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [OFS_W-1:0]  wr_ofs,
  input  logic [DATA_W-1:0] wr_data
);
  logic [DATA_W-1:0] word_q [LINES][WORDS];

  for (genvar l = 0; l < LINES; l++) begin : g_line
    for (genvar w = 0; w < WORDS; w++) begin : g_word
      logic ce;
      assign ce = wr_en && (idx == IDX_W'(l)) && (wr_ofs == OFS_W'(w));
      always_ff @(posedge clk) begin
        if (ce) begin
          word_q[l][w] <= wr_data;
        end
      end
    end
  end

  assign rd_data = word_q[idx][rd_ofs];
endmodule

// File: rtl/dcg_ctrl.sv
module dcg_ctrl
  import dcg_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 4,
  parameter int OFS_W  = 2,
  localparam int TAG_W = ADDR_W - IDX_W - OFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cache_en,
  input  logic              xlat_en,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              req_cacheable,
  input  logic              req_wthru,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_write,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [IDX_W-1:0]  lk_idx,
  input  logic              lk_valid,
  input  logic              lk_dirty,
  input  logic [TAG_W-1:0]  lk_tag,
  output logic              inv_en,
  output logic              fill_en,
  output logic [TAG_W-1:0]  fill_tag,
  output logic              dirty_en,
  output logic [OFS_W-1:0]  ar_rd_ofs,
  input  logic [DATA_W-1:0] ar_rd_data,
  output logic              ar_wr_en,
  output logic [OFS_W-1:0]  ar_wr_ofs,
  output logic [DATA_W-1:0] ar_wr_data
);
  localparam logic [OFS_W-1:0] LAST_BEAT = '1;

  dcg_state_t        state_q, state_d;
  logic              wr_q, wr_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] wdata_q, wdata_d;
  logic              cach_q, cach_d;
  logic              wt_q, wt_d;
  logic [OFS_W-1:0]  beat_q, beat_d;
  logic              rsp_valid_q, rsp_valid_d;
  logic [DATA_W-1:0] rsp_rdata_q, rsp_rdata_d;

  logic [TAG_W-1:0]  tag_w;
  logic [IDX_W-1:0]  idx_w;
  logic [OFS_W-1:0]  ofs_w;
  logic              hit;
  logic              alloc_ok;
  logic              accept;

  assign tag_w    = addr_q[ADDR_W-1 -: TAG_W];
  assign idx_w    = addr_q[OFS_W +: IDX_W];
  assign ofs_w    = addr_q[OFS_W-1:0];
  assign hit      = lk_valid && (lk_tag == tag_w);
  assign alloc_ok = cache_en && xlat_en && cach_q;
  assign accept   = req_valid && req_ready;

  assign lk_idx    = idx_w;
  assign fill_tag  = tag_w;
  assign req_ready = (state_q == ST_IDLE);
  assign rsp_valid = rsp_valid_q;
  assign rsp_rdata = rsp_rdata_q;

  always_comb begin
    state_d     = state_q;
    wr_d        = wr_q;
    addr_d      = addr_q;
    wdata_d     = wdata_q;
    cach_d      = cach_q;
    wt_d        = wt_q;
    beat_d      = beat_q;
    rsp_valid_d = 1'b0;
    rsp_rdata_d = rsp_rdata_q;
    inv_en      = 1'b0;
    fill_en     = 1'b0;
    dirty_en    = 1'b0;
    ar_rd_ofs   = ofs_w;
    ar_wr_en    = 1'b0;
    ar_wr_ofs   = ofs_w;
    ar_wr_data  = wdata_q;
    mem_valid   = 1'b0;
    mem_write   = 1'b0;
    mem_addr    = addr_q;
    mem_wdata   = wdata_q;

    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          wr_d    = req_write;
          addr_d  = req_addr;
          wdata_d = req_wdata;
          cach_d  = req_cacheable;
          wt_d    = req_wthru;
          state_d = ST_LOOK;
        end
      end
      ST_LOOK: begin
        if (hit) begin
          if (!wr_q) begin
            rsp_valid_d = 1'b1;
            rsp_rdata_d = ar_rd_data;
            state_d     = ST_IDLE;
          end else begin
            ar_wr_en = 1'b1;
            if (wt_q) begin
              state_d = ST_WT;
            end else begin
              dirty_en    = 1'b1;
              rsp_valid_d = 1'b1;
              rsp_rdata_d = '0;
              state_d     = ST_IDLE;
            end
          end
        end else if (alloc_ok) begin
          beat_d = '0;
          if (lk_valid && lk_dirty) begin
            state_d = ST_EVICT;
          end else begin
            inv_en  = 1'b1;
            state_d = ST_FILL;
          end
        end else begin
          state_d = ST_PASS;
        end
      end
      ST_EVICT: begin
        ar_rd_ofs = beat_q;
        mem_valid = 1'b1;
        mem_write = 1'b1;
        mem_addr  = {lk_tag, idx_w, beat_q};
        mem_wdata = ar_rd_data;
        if (mem_ready) begin
          beat_d = beat_q + 1'b1;
          if (beat_q == LAST_BEAT) begin
            inv_en  = 1'b1;
            state_d = ST_FILL;
          end
        end
      end
      ST_FILL: begin
        mem_valid  = 1'b1;
        mem_addr   = {tag_w, idx_w, beat_q};
        ar_wr_ofs  = beat_q;
        ar_wr_data = mem_rdata;
        if (mem_ready) begin
          ar_wr_en = 1'b1;
          beat_d   = beat_q + 1'b1;
          if (beat_q == LAST_BEAT) begin
            fill_en = 1'b1;
            state_d = ST_LOOK;
          end
        end
      end
      ST_PASS: begin
        mem_valid = 1'b1;
        mem_write = wr_q;
        if (mem_ready) begin
          rsp_valid_d = 1'b1;
          rsp_rdata_d = wr_q ? '0 : mem_rdata;
          state_d     = ST_IDLE;
        end
      end
      ST_WT: begin
        mem_valid = 1'b1;
        mem_write = 1'b1;
        if (mem_ready) begin
          rsp_valid_d = 1'b1;
          rsp_rdata_d = '0;
          state_d     = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      rsp_valid_q <= 1'b0;
      beat_q      <= '0;
    end else begin
      state_q     <= state_d;
      rsp_valid_q <= rsp_valid_d;
      beat_q      <= beat_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q        <= 1'b0;
      addr_q      <= '0;
      wdata_q     <= '0;
      cach_q      <= 1'b0;
      wt_q        <= 1'b0;
      rsp_rdata_q <= '0;
    end else begin
      if (accept) begin
        wr_q    <= wr_d;
        addr_q  <= addr_d;
        wdata_q <= wdata_d;
        cach_q  <= cach_d;
        wt_q    <= wt_d;
      end
      if (rsp_valid_d) begin
        rsp_rdata_q <= rsp_rdata_d;
      end
    end
  end

  // R10: no memory beat while the request port is open
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_valid);

  // R10: a stalled memory beat holds its fields
  p_mem_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) &&
                                   $stable(mem_write) && $stable(mem_wdata)));

  // R11: the response is a single-cycle pulse
  p_rsp_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R5: refill only starts when all three enables were set at lookup
  p_fill_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FILL && $past(state_q) == ST_LOOK) |->
      $past(cache_en && xlat_en && cach_q));

  // R9: the write-back of a victim runs straight into the refill
  p_evict_then_fill_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_EVICT && mem_ready && beat_q == LAST_BEAT) |=>
      (state_q == ST_FILL && beat_q == '0));

  // R4: a completed write-through beat is answered in the next cycle
  p_wt_answer_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WT && mem_ready) |=> rsp_valid);

  // R8: a refill is followed by a fresh lookup
  p_fill_relook_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |=> (state_q == ST_LOOK));
endmodule

// File: rtl/dcache_gated.sv
module dcache_gated #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 4,
  parameter int OFS_W  = 2,
  localparam int TAG_W = ADDR_W - IDX_W - OFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_cache_en,
  input  logic              cfg_xlat_en,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              req_cacheable,
  input  logic              req_wthru,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_write,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata
);
  logic rst_meta_q, rst_sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic [IDX_W-1:0]  lk_idx;
  logic              lk_valid, lk_dirty;
  logic [TAG_W-1:0]  lk_tag;
  logic              inv_en, fill_en, dirty_en;
  logic [TAG_W-1:0]  fill_tag;
  logic [OFS_W-1:0]  ar_rd_ofs, ar_wr_ofs;
  logic [DATA_W-1:0] ar_rd_data, ar_wr_data;
  logic              ar_wr_en;

  dcg_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W), .OFS_W(OFS_W)
  ) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_sync_q),
    .cache_en      (cfg_cache_en),
    .xlat_en       (cfg_xlat_en),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_write     (req_write),
    .req_addr      (req_addr),
    .req_wdata     (req_wdata),
    .req_cacheable (req_cacheable),
    .req_wthru     (req_wthru),
    .rsp_valid     (rsp_valid),
    .rsp_rdata     (rsp_rdata),
    .mem_valid     (mem_valid),
    .mem_ready     (mem_ready),
    .mem_write     (mem_write),
    .mem_addr      (mem_addr),
    .mem_wdata     (mem_wdata),
    .mem_rdata     (mem_rdata),
    .lk_idx        (lk_idx),
    .lk_valid      (lk_valid),
    .lk_dirty      (lk_dirty),
    .lk_tag        (lk_tag),
    .inv_en        (inv_en),
    .fill_en       (fill_en),
    .fill_tag      (fill_tag),
    .dirty_en      (dirty_en),
    .ar_rd_ofs     (ar_rd_ofs),
    .ar_rd_data    (ar_rd_data),
    .ar_wr_en      (ar_wr_en),
    .ar_wr_ofs     (ar_wr_ofs),
    .ar_wr_data    (ar_wr_data)
  );

  dcg_tag_array #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .idx      (lk_idx),
    .rd_valid (lk_valid),
    .rd_dirty (lk_dirty),
    .rd_tag   (lk_tag),
    .inv_en   (inv_en),
    .fill_en  (fill_en),
    .fill_tag (fill_tag),
    .dirty_en (dirty_en)
  );

  dcg_data_array #(.IDX_W(IDX_W), .OFS_W(OFS_W), .DATA_W(DATA_W)) u_data (
    .clk     (clk),
    .idx     (lk_idx),
    .rd_ofs  (ar_rd_ofs),
    .rd_data (ar_rd_data),
    .wr_en   (ar_wr_en),
    .wr_ofs  (ar_wr_ofs),
    .wr_data (ar_wr_data)
  );

  // R1: nothing leaves the block while reset is held internally
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_sync_q |-> (!mem_valid && !rsp_valid));
endmodule

// File: tb/dcache_gated_tb.sv
module dcache_gated_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_cache_en = 1'b1, cfg_xlat_en = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        req_cacheable = 1'b0, req_wthru = 1'b0;
  logic        req_ready, rsp_valid, mem_valid, mem_write;
  logic [31:0] rsp_rdata, mem_wdata, mem_rdata;
  logic [15:0] mem_addr;
  logic        mem_ready = 1'b1;

  always #4 clk = ~clk;

  dcache_gated u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_cache_en(cfg_cache_en), .cfg_xlat_en(cfg_xlat_en),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_cacheable(req_cacheable),
    .req_wthru(req_wthru), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_write(mem_write),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  logic [31:0] mem [1024];
  logic [31:0] shadow [1024];
  logic [15:0] ev_addr [16];
  logic        ev_wr [16];
  int          ev_n = 0, rd_cnt = 0, wr_cnt = 0;
  int          errors = 0, checks = 0, pulse_bad = 0, busy_bad = 0;
  bit          stall = 1'b0;
  int          cyc = 0;

  assign mem_rdata = mem[mem_addr[9:0]];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_valid && mem_ready) begin
      if (ev_n < 16) begin
        ev_addr[ev_n] = mem_addr;
        ev_wr[ev_n]   = mem_write;
      end
      ev_n = ev_n + 1;
      if (mem_write) begin
        mem[mem_addr[9:0]] = mem_wdata;
        wr_cnt = wr_cnt + 1;
      end else begin
        rd_cnt = rd_cnt + 1;
      end
    end
  end

  always @(negedge clk) mem_ready <= stall ? (cyc % 4 == 3) : 1'b1;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clr();
    ev_n = 0; rd_cnt = 0; wr_cnt = 0;
  endtask

  task automatic acc(input logic wr, input logic [15:0] a, input logic [31:0] wd,
                     input logic ca, input logic wt,
                     output logic [31:0] rd, output int lat);
    @(negedge clk);
    req_write = wr; req_addr = a; req_wdata = wd;
    req_cacheable = ca; req_wthru = wt; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    if (req_ready) busy_bad++;
    while (!rsp_valid && lat < 400) begin
      @(negedge clk);
      lat++;
    end
    rd = rsp_rdata;
    if (!rsp_valid) chk(1'b0, "R11 response timeout", 0, 1);
    @(negedge clk);
    if (rsp_valid) pulse_bad++;
    if (wr) shadow[a[9:0]] = wd;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", cyc, 150000);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int lat;
    for (int i = 0; i < 1024; i++) begin
      mem[i]    = 32'hC0DE0000 + 32'(i * 7);
      shadow[i] = mem[i];
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1: idle after reset
    chk(req_ready && !rsp_valid && !mem_valid, "R1 reset outputs",
        {req_ready, rsp_valid, mem_valid}, 3'b100);

    // R5/R6: sweep of the three allocation enables, one line per combination
    for (int c = 0; c < 8; c++) begin
      logic [15:0] a;
      bit all_on;
      a = 16'(c * 4 + 1);
      all_on = (c == 7);
      cfg_cache_en = c[0]; cfg_xlat_en = c[1];
      clr();
      acc(1'b0, a, 32'h0, c[2], 1'b0, rd, lat);
      chk(rd == shadow[a[9:0]], "R6 miss load data", rd, shadow[a[9:0]]);
      chk(rd_cnt == (all_on ? 4 : 1), "R5 miss read count", rd_cnt, all_on ? 4 : 1);
      if (!all_on) begin
        chk(ev_addr[0] == a, "R6 pass-through address", ev_addr[0], a);
      end else begin
        for (int b = 0; b < 4; b++)
          chk(ev_addr[b] == 16'(c * 4 + b), "R8 fill order", ev_addr[b], c * 4 + b);
      end
      clr();
      acc(1'b0, a, 32'h0, c[2], 1'b0, rd, lat);
      chk(rd_cnt == (all_on ? 0 : 1), "R5 repeat read count", rd_cnt, all_on ? 0 : 1);
      chk(rd == shadow[a[9:0]], "R2 repeat data", rd, shadow[a[9:0]]);
    end

    // R2: fill all lines with tag 1, then read every word back
    cfg_cache_en = 1'b1; cfg_xlat_en = 1'b1;
    for (int l = 0; l < 16; l++) begin
      clr();
      acc(1'b0, 16'(64 + l * 4), 32'h0, 1'b1, 1'b0, rd, lat);
      chk(wr_cnt == 0 && rd_cnt == 4, "R5 clean allocation", {wr_cnt, rd_cnt}, 4);
    end
    for (int w = 0; w < 64; w++) begin
      clr();
      acc(1'b0, 16'(64 + w), 32'h0, 1'b1, 1'b0, rd, lat);
      chk(rd == shadow[64 + w] && ev_n == 0 && lat == 2, "R2 hit sweep",
          {rd, 8'(ev_n), 8'(lat)}, {shadow[64 + w], 8'd0, 8'd2});
    end

    // R3: write-back store hit
    clr();
    acc(1'b1, 16'd78, 32'hDEAD0001, 1'b1, 1'b0, rd, lat);
    chk(ev_n == 0, "R3 no memory traffic", ev_n, 0);
    clr();
    acc(1'b0, 16'd78, 32'h0, 1'b1, 1'b0, rd, lat);
    chk(rd == 32'hDEAD0001 && ev_n == 0, "R3 readback", rd, 32'hDEAD0001);
    chk(mem[78] != 32'hDEAD0001, "R3 memory stale", mem[78], 0);

    // R9: conflicting miss evicts the dirty line (tag1 idx3 -> tag2 idx3)
    clr();
    stall = 1'b1;
    acc(1'b0, 16'd140, 32'h0, 1'b1, 1'b0, rd, lat);
    stall = 1'b0;
    chk(wr_cnt == 4 && rd_cnt == 4, "R9 evict and fill counts", {wr_cnt, rd_cnt}, 8);
    for (int b = 0; b < 4; b++) begin
      chk(ev_wr[b] && ev_addr[b] == 16'(76 + b), "R9 victim write order", ev_addr[b], 76 + b);
      chk(!ev_wr[4 + b] && ev_addr[4 + b] == 16'(140 + b), "R8 refill order",
          ev_addr[4 + b], 140 + b);
    end
    chk(mem[78] == 32'hDEAD0001, "R9 victim data in memory", mem[78], 32'hDEAD0001);
    chk(rd == shadow[140], "R2 load after refill", rd, shadow[140]);

    // R4: write-through store hit with a throttled memory
    clr();
    stall = 1'b1;
    acc(1'b1, 16'd141, 32'hBEEF0002, 1'b1, 1'b1, rd, lat);
    stall = 1'b0;
    chk(wr_cnt == 1 && rd_cnt == 0 && ev_addr[0] == 16'd141, "R4 single write",
        {wr_cnt, ev_addr[0]}, 141);
    chk(mem[141] == 32'hBEEF0002, "R4 memory data", mem[141], 32'hBEEF0002);
    clr();
    acc(1'b0, 16'd141, 32'h0, 1'b1, 1'b0, rd, lat);
    chk(rd == 32'hBEEF0002 && ev_n == 0, "R4 cache updated", rd, 32'hBEEF0002);

    // R7: lookups go on with the cache disabled
    cfg_cache_en = 1'b0;
    clr();
    acc(1'b0, 16'd141, 32'h0, 1'b1, 1'b0, rd, lat);
    chk(rd == 32'hBEEF0002 && ev_n == 0, "R7 disabled load hit", rd, 32'hBEEF0002);
    clr();
    acc(1'b1, 16'd143, 32'h5A5A0003, 1'b1, 1'b0, rd, lat);
    chk(ev_n == 0, "R7 disabled store hit no traffic", ev_n, 0);
    clr();
    acc(1'b0, 16'd204, 32'h0, 1'b1, 1'b0, rd, lat);
    chk(rd_cnt == 1 && wr_cnt == 0 && rd == shadow[204], "R7 disabled miss passes",
        {rd_cnt, wr_cnt}, 1);
    clr();
    acc(1'b0, 16'd143, 32'h0, 1'b1, 1'b0, rd, lat);
    chk(rd == 32'h5A5A0003 && ev_n == 0, "R7 resident line kept", rd, 32'h5A5A0003);

    // R6: non-cacheable store miss with the cache enabled
    cfg_cache_en = 1'b1;
    clr();
    acc(1'b1, 16'd357, 32'h12345678, 1'b0, 1'b0, rd, lat);
    chk(wr_cnt == 1 && mem[357] == 32'h12345678, "R6 store pass-through",
        mem[357], 32'h12345678);
    clr();
    acc(1'b0, 16'd357, 32'h0, 1'b0, 1'b0, rd, lat);
    chk(rd == 32'h12345678 && rd_cnt == 1, "R6 load pass-through", rd, 32'h12345678);

    // R10/R11: handshake held closed while busy, single-cycle responses
    chk(busy_bad == 0, "R10 ready while busy", busy_bad, 0);
    chk(pulse_bad == 0, "R11 response pulse width", pulse_bad, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule